// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the wakeup logic and the execution units of an out-of-order core. Instructions whose operands are ready are pushed into one of several per-class ready queues. Each queue is kept sorted by sequence number, so its head is always its oldest instruction. Every cycle the selector ranks the non-empty classes by the age of their heads and walks them from oldest to youngest. It sends up to `W` instructions to the issue slots.

For every class it visits, the selector does one of three things. A squashed head is discarded without taking a slot. A head is issued if its class has a functional unit available, or if the class needs no unit. Otherwise the class is skipped for this cycle and a busy event is raised. For each issued instruction the selector times the unit it used. It reports when that unit is released and when a multi-cycle operation completes. It also reports how many queue entries were freed by this cycle's issues.

Sequence numbers are compared as plain unsigned values. Class index 0 is the class that needs no functional unit.

Top module: `iss_sel_top`

## Requirements
- R1: After reset all queues are empty, and no issue slot, busy, release or completion output is asserted.
- R2: Each cycle, visited classes are taken in ascending order of their head sequence number. Each class offers only its head, at most once per cycle. Issued instructions fill slots from slot 0 upward in that order, and at most `W` issue per cycle. A push becomes eligible for issue in the cycle after it is accepted.
- R3: A push older than the current head of its class becomes that class's head and competes with its new age from the next cycle.
- R4: While `downstream_ready_i` is low, nothing is issued, discarded or reported busy, and every queued instruction is kept.
- R5: A squashed head reached by the walk is removed without using a slot or freeing an entry count. The walk continues with the next class. The class's next head waits for a later cycle.
- R6: A class with a unit needed but not available (`fu_avail_i[c]` low, or its own non-pipelined unit still busy) is skipped. Its `busy_skip_o[c]` pulses, and younger classes may still issue.
- R7: Class 0 issues regardless of `fu_avail_i`. It never pulses busy, release or completion.
- R8: An instruction of class c≥1 with operation latency ≤1 pulses `fu_release_o[c]` in the cycle after its issue. No completion follows.
- R9: An instruction with operation latency >1 on a pipelined unit (issue latency ≤1) pulses `fu_release_o[c]` in the next cycle. It also pulses `cmp_valid_o[c]` in the next cycle, with its sequence number and thread.
- R10: An instruction with operation latency >1 on a non-pipelined unit (issue latency L>1) raises completion and release together, L−1 cycles after the issue cycle. Until then its class is treated as unavailable.
- R11: `entry_free_o` equals the number of non-memory instructions issued this cycle. Memory instructions and discarded squashed heads add nothing.
- R12: A push to a class queue that already holds `DEPTH` entries at the start of the cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | Push a ready instruction this cycle |
| push_cls_i | input | CLS_W | Operation class of the push (0 = no unit) |
| push_seq_i | input | SEQ_W | Sequence number (smaller is older) |
| push_tid_i | input | TID_W | Thread of the push |
| push_squashed_i | input | 1 | Instruction already squashed |
| push_mem_i | input | 1 | Memory instruction (keeps its entry at issue) |
| downstream_ready_i | input | 1 | Execute stage can accept instructions |
| fu_avail_i | input | NCLS | Unit available per class |
| op_lat_i | input | NCLS×LAT_W | Operation latency per class |
| iss_lat_i | input | NCLS×LAT_W | Issue latency per class (>1 means non-pipelined) |
| iss_valid_o | output | W | Issue slot valid |
| iss_seq_o | output | W×SEQ_W | Issued sequence number per slot |
| iss_tid_o | output | W×TID_W | Issued thread per slot |
| iss_cls_o | output | W×CLS_W | Issued class per slot |
| iss_mem_o | output | W | Issued instruction is memory |
| busy_skip_o | output | NCLS | Class skipped this cycle for lack of a unit |
| fu_release_o | output | NCLS | Unit of the class released this cycle |
| cmp_valid_o | output | NCLS | Multi-cycle operation completes this cycle |
| cmp_seq_o | output | NCLS×SEQ_W | Sequence number of the completing operation |
| cmp_tid_o | output | NCLS×TID_W | Thread of the completing operation |
| entry_free_o | output | FREE_W | Queue entries freed by this cycle's issues |

## Verification
The bench goes after the age ordering across classes, including a late push that is older than an existing head. A design that kept a stale ranking would issue the younger instruction first. It places a squashed head ahead of valid ones. A design that charged bandwidth for the squashed head would leave a slot empty, and one that counted it as freed would overstate `entry_free_o`. It withholds a unit and then drives a non-pipelined operation. A wrong design would stall younger classes behind the busy one, or issue a second operation before completion. It overfills a queue with an older instruction, which a design that accepted the push would later issue.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;
  parameter int SEQ_W  = 16;
  parameter int TID_W  = 2;
  parameter int LAT_W  = 4;
  parameter int NOUNIT = 0;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [TID_W-1:0] tid;
    logic             sq;
    logic             mem;
  } ready_ent_t;

  // true when entry a (class ia) ranks before entry b (class ib)
  function automatic logic ranks_first(input logic [SEQ_W-1:0] a, input int ia,
                                       input logic [SEQ_W-1:0] b, input int ib);
    return (a < b) || ((a == b) && (ia < ib));
  endfunction

  function automatic logic multi_cycle(input logic [LAT_W-1:0] op);
    return op > LAT_W'(1);
  endfunction

  function automatic logic non_pipelined(input logic [LAT_W-1:0] il);
    return il > LAT_W'(1);
  endfunction

  // cycles from issue to completion, never below one
  function automatic logic [LAT_W-1:0] done_delay(input logic [LAT_W-1:0] il);
    return non_pipelined(il) ? il - LAT_W'(1) : LAT_W'(1);
  endfunction
endpackage

// File: rtl/iss_ready_q.sv
module iss_ready_q
  import iss_sel_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_en_i,
  input  ready_ent_t push_ent_i,
  input  logic       pop_en_i,
  output ready_ent_t head_o,
  output logic       nonempty_o
);
  ready_ent_t ent_q [DEPTH];
  ready_ent_t shr   [DEPTH];
  ready_ent_t up    [DEPTH];
  ready_ent_t nxt   [DEPTH];
  logic [CW-1:0] cnt_q, cnt_sh, cnt_nxt, slot;

  always_comb begin
    // remove the head first
    cnt_sh = cnt_q;
    for (int i = 0; i < DEPTH; i++) shr[i] = ent_q[i];
    if (pop_en_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) shr[i] = ent_q[i + 1];
      shr[DEPTH-1] = '0;
      cnt_sh = cnt_q - CW'(1);
    end
    // insertion point: after every entry not younger than the push
    slot = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt_sh && shr[i].seq <= push_ent_i.seq) slot = slot + CW'(1);
    up[0] = shr[0];
    for (int i = 1; i < DEPTH; i++) up[i] = shr[i - 1];
    cnt_nxt = cnt_sh;
    for (int i = 0; i < DEPTH; i++) nxt[i] = shr[i];
    if (push_en_i && cnt_q < CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == slot)     nxt[i] = push_ent_i;
        else if (CW'(i) > slot) nxt[i] = up[i];
      end
      cnt_nxt = cnt_sh + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= nxt[i];
    end
  end

  assign head_o     = ent_q[0];
  assign nonempty_o = cnt_q != '0;
endmodule

// File: rtl/iss_pick.sv
module iss_pick
  import iss_sel_pkg::*;
#(
  parameter int NCLS = 4,
  parameter int W    = 2,
  localparam int CLS_W = $clog2(NCLS)
) (
  input  ready_ent_t [NCLS-1:0]  heads_i,
  input  logic [NCLS-1:0]        valid_i,
  input  logic [NCLS-1:0]        avail_i,
  input  logic                   dn_ready_i,
  output logic [NCLS-1:0]        pop_o,
  output logic [NCLS-1:0]        go_o,
  output logic [NCLS-1:0]        busy_o,
  output logic [W-1:0]           slot_v_o,
  output ready_ent_t [W-1:0]     slot_ent_o,
  output logic [W-1:0][CLS_W-1:0] slot_cls_o
);
  int rank [NCLS];
  int n;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      rank[c] = 0;
      for (int d = 0; d < NCLS; d++)
        if (d != c && valid_i[d] && ranks_first(heads_i[d].seq, d, heads_i[c].seq, c))
          rank[c] = rank[c] + 1;
    end
    pop_o = '0; go_o = '0; busy_o = '0;
    slot_v_o = '0; slot_ent_o = '0; slot_cls_o = '0;
    n = 0;
    for (int p = 0; p < NCLS; p++)
      for (int c = 0; c < NCLS; c++)
        if (dn_ready_i && valid_i[c] && rank[c] == p && n < W) begin
          if (heads_i[c].sq) begin
            pop_o[c] = 1'b1;
          end else if (avail_i[c] || c == NOUNIT) begin
            pop_o[c]      = 1'b1;
            go_o[c]       = 1'b1;
            slot_v_o[n]   = 1'b1;
            slot_ent_o[n] = heads_i[c];
            slot_cls_o[n] = CLS_W'(c);
            n = n + 1;
          end else begin
            busy_o[c] = 1'b1;
          end
        end
  end
endmodule

// File: rtl/iss_fu_timer.sv
module iss_fu_timer
  import iss_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [LAT_W-1:0] op_lat_i,
  input  logic [LAT_W-1:0] iss_lat_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [TID_W-1:0] tid_i,
  output logic             release_o,
  output logic             cmp_o,
  output logic             hold_o,
  output logic [SEQ_W-1:0] cmp_seq_o,
  output logic [TID_W-1:0] cmp_tid_o
);
  logic [LAT_W-1:0] cnt_q;
  logic             np_q, rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; np_q <= 1'b0; rel_q <= 1'b0;
      cmp_seq_o <= '0; cmp_tid_o <= '0;
    end else begin
      rel_q <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - LAT_W'(1);
      if (go_i) begin
        if (multi_cycle(op_lat_i)) begin
          cnt_q     <= done_delay(iss_lat_i);
          np_q      <= non_pipelined(iss_lat_i);
          rel_q     <= !non_pipelined(iss_lat_i);
          cmp_seq_o <= seq_i;
          cmp_tid_o <= tid_i;
        end else begin
          rel_q <= 1'b1;
        end
      end
    end
  end

  assign cmp_o     = cnt_q == LAT_W'(1);
  assign release_o = rel_q | (cmp_o & np_q);
  assign hold_o    = np_q & (cnt_q != '0);
endmodule

// File: rtl/iss_sel_top.sv
module iss_sel_top
  import iss_sel_pkg::*;
#(
  parameter int NCLS  = 4,
  parameter int DEPTH = 8,
  parameter int W     = 2,
  localparam int CLS_W  = $clog2(NCLS),
  localparam int FREE_W = $clog2(W + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_valid_i,
  input  logic [CLS_W-1:0]              push_cls_i,
  input  logic [SEQ_W-1:0]              push_seq_i,
  input  logic [TID_W-1:0]              push_tid_i,
  input  logic                          push_squashed_i,
  input  logic                          push_mem_i,
  input  logic                          downstream_ready_i,
  input  logic [NCLS-1:0]               fu_avail_i,
  input  logic [NCLS-1:0][LAT_W-1:0]    op_lat_i,
  input  logic [NCLS-1:0][LAT_W-1:0]    iss_lat_i,
  output logic [W-1:0]                  iss_valid_o,
  output logic [W-1:0][SEQ_W-1:0]       iss_seq_o,
  output logic [W-1:0][TID_W-1:0]       iss_tid_o,
  output logic [W-1:0][CLS_W-1:0]       iss_cls_o,
  output logic [W-1:0]                  iss_mem_o,
  output logic [NCLS-1:0]               busy_skip_o,
  output logic [NCLS-1:0]               fu_release_o,
  output logic [NCLS-1:0]               cmp_valid_o,
  output logic [NCLS-1:0][SEQ_W-1:0]    cmp_seq_o,
  output logic [NCLS-1:0][TID_W-1:0]    cmp_tid_o,
  output logic [FREE_W-1:0]             entry_free_o
);
  // named internal events, observed by the bound checker
  ready_ent_t [NCLS-1:0] head_w;
  ready_ent_t [W-1:0]    slot_w;
  ready_ent_t            push_ent_w;
  logic [NCLS-1:0]       nonempty_w, pop_w, go_w, hold_w, avail_eff_w;

  function automatic logic [FREE_W-1:0] freed(input logic [W-1:0] v, input logic [W-1:0] m);
    logic [FREE_W-1:0] k = '0;
    for (int i = 0; i < W; i++) if (v[i] && !m[i]) k = k + FREE_W'(1);
    return k;
  endfunction

  assign push_ent_w  = '{seq: push_seq_i, tid: push_tid_i, sq: push_squashed_i, mem: push_mem_i};
  assign avail_eff_w = fu_avail_i & ~hold_w;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    iss_ready_q #(.DEPTH(DEPTH)) u_q (
      .clk, .rst_n,
      .push_en_i  (push_valid_i && push_cls_i == CLS_W'(c)),
      .push_ent_i (push_ent_w),
      .pop_en_i   (pop_w[c]),
      .head_o     (head_w[c]),
      .nonempty_o (nonempty_w[c])
    );
    if (c == NOUNIT) begin : g_nounit
      logic unused_lat;
      assign unused_lat      = ^{op_lat_i[c], iss_lat_i[c]};
      assign hold_w[c]       = 1'b0;
      assign fu_release_o[c] = 1'b0;
      assign cmp_valid_o[c]  = 1'b0;
      assign cmp_seq_o[c]    = '0;
      assign cmp_tid_o[c]    = '0;
    end else begin : g_unit
      iss_fu_timer u_t (
        .clk, .rst_n,
        .go_i      (go_w[c]),
        .op_lat_i  (op_lat_i[c]),
        .iss_lat_i (iss_lat_i[c]),
        .seq_i     (head_w[c].seq),
        .tid_i     (head_w[c].tid),
        .release_o (fu_release_o[c]),
        .cmp_o     (cmp_valid_o[c]),
        .hold_o    (hold_w[c]),
        .cmp_seq_o (cmp_seq_o[c]),
        .cmp_tid_o (cmp_tid_o[c])
      );
    end
  end

  iss_pick #(.NCLS(NCLS), .W(W)) u_pick (
    .heads_i    (head_w),
    .valid_i    (nonempty_w),
    .avail_i    (avail_eff_w),
    .dn_ready_i (downstream_ready_i),
    .pop_o      (pop_w),
    .go_o       (go_w),
    .busy_o     (busy_skip_o),
    .slot_v_o   (iss_valid_o),
    .slot_ent_o (slot_w),
    .slot_cls_o (iss_cls_o)
  );

  always_comb begin
    for (int i = 0; i < W; i++) begin
      iss_seq_o[i] = slot_w[i].seq;
      iss_tid_o[i] = slot_w[i].tid;
      iss_mem_o[i] = slot_w[i].mem;
    end
  end

  assign entry_free_o = freed(iss_valid_o, iss_mem_o);
endmodule

// File: rtl/iss_sel_chk.sv
module iss_sel_chk
  import iss_sel_pkg::*;
#(
  parameter int NCLS = 4,
  parameter int W    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       downstream_ready_i,
  input logic [NCLS-1:0]            fu_avail_i,
  input logic [NCLS-1:0][LAT_W-1:0] op_lat_i,
  input logic [W-1:0]               iss_valid_o,
  input logic [W-1:0][SEQ_W-1:0]    iss_seq_o,
  input logic [NCLS-1:0]            busy_skip_o,
  input logic [NCLS-1:0]            fu_release_o,
  input logic [NCLS-1:0]            cmp_valid_o,
  input logic [NCLS-1:0]            go_w,
  input logic [NCLS-1:0]            hold_w,
  input logic [NCLS-1:0]            pop_w
);
  a_r2_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_o & (iss_valid_o + W'(1))) == '0);

  for (genvar i = 1; i < W; i++) begin : g_ord
    a_r2_age_order: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid_o[i] |-> (iss_valid_o[i-1] && iss_seq_o[i-1] <= iss_seq_o[i]));
  end

  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !downstream_ready_i |-> (iss_valid_o == '0 && pop_w == '0 && busy_skip_o == '0));

  a_r6_busy_needs_no_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_skip_o & fu_avail_i & ~hold_w) == '0);

  a_r7_nounit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_skip_o[NOUNIT] && !fu_release_o[NOUNIT] && !cmp_valid_o[NOUNIT]);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    if (c != NOUNIT) begin : g_u
      a_r8_release_next: assert property (@(posedge clk) disable iff (!rst_n)
        (go_w[c] && op_lat_i[c] <= LAT_W'(1)) |=> fu_release_o[c]);
      a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_w[c] |-> !go_w[c]);
    end
  end
endmodule

bind iss_sel_top iss_sel_chk #(.NCLS(NCLS), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .downstream_ready_i(downstream_ready_i),
  .fu_avail_i(fu_avail_i), .op_lat_i(op_lat_i), .iss_valid_o(iss_valid_o),
  .iss_seq_o(iss_seq_o), .busy_skip_o(busy_skip_o), .fu_release_o(fu_release_o),
  .cmp_valid_o(cmp_valid_o), .go_w(go_w), .hold_w(hold_w), .pop_w(pop_w)
);

// File: tb/tb_iss_sel_top.sv
module tb_iss_sel_top;
  localparam int NCLS = 4, DEPTH = 8, W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic push_valid, push_sq, push_mem, dn_ready;
  logic [1:0] push_cls, push_tid;
  logic [15:0] push_seq;
  logic [NCLS-1:0] fu_avail;
  logic [NCLS-1:0][3:0] op_lat, iss_lat;
  logic [W-1:0] iss_valid, iss_mem;
  logic [W-1:0][15:0] iss_seq;
  logic [W-1:0][1:0] iss_tid, iss_cls;
  logic [NCLS-1:0] busy_skip, fu_release, cmp_valid;
  logic [NCLS-1:0][15:0] cmp_seq;
  logic [NCLS-1:0][1:0] cmp_tid;
  logic [1:0] entry_free;

  iss_sel_top #(.NCLS(NCLS), .DEPTH(DEPTH), .W(W)) dut (
    .clk, .rst_n, .push_valid_i(push_valid), .push_cls_i(push_cls), .push_seq_i(push_seq),
    .push_tid_i(push_tid), .push_squashed_i(push_sq), .push_mem_i(push_mem),
    .downstream_ready_i(dn_ready), .fu_avail_i(fu_avail), .op_lat_i(op_lat), .iss_lat_i(iss_lat),
    .iss_valid_o(iss_valid), .iss_seq_o(iss_seq), .iss_tid_o(iss_tid), .iss_cls_o(iss_cls),
    .iss_mem_o(iss_mem), .busy_skip_o(busy_skip), .fu_release_o(fu_release),
    .cmp_valid_o(cmp_valid), .cmp_seq_o(cmp_seq), .cmp_tid_o(cmp_tid), .entry_free_o(entry_free)
  );

  int checks = 0, errors = 0;
  bit fin = 0;
  // staged stimulus
  logic p_v = 0, p_q = 0, p_m = 0, dr = 0;
  int p_c = 0, p_s = 0, p_t = 0;
  logic [NCLS-1:0] fav = '1;
  int opl[NCLS], isl[NCLS];
  // reference state: unsorted per-class pools and per-class unit timers
  int mseq[NCLS][DEPTH], mtid[NCLS][DEPTH], msq[NCLS][DEPTH], mmem[NCLS][DEPTH], mcnt[NCLS];
  int mt[NCLS], mnp[NCLS], mrel[NCLS], mps[NCLS], mpt[NCLS];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int oldest(int c);
    int h = 0;
    for (int i = 1; i < mcnt[c]; i++) if (mseq[c][i] < mseq[c][h]) h = i;
    return h;
  endfunction

  function automatic int delay_of(int il);
    return (il > 1) ? il - 1 : 1;
  endfunction

  task automatic step(string tag);
    logic [NCLS-1:0] seen, e_busy, e_go, e_cmp, e_rel, e_pop;
    logic [W-1:0] e_v;
    int es[W], et[W], ec[W], em[W];
    int n, best, h, e_free, nt;
    bit full_pre;
    @(negedge clk);
    push_valid = p_v; push_cls = 2'(p_c); push_seq = 16'(p_s); push_tid = 2'(p_t);
    push_sq = p_q; push_mem = p_m; dn_ready = dr; fu_avail = fav;
    for (int c = 0; c < NCLS; c++) begin op_lat[c] = 4'(opl[c]); iss_lat[c] = 4'(isl[c]); end
    #1;
    seen = '0; e_busy = '0; e_go = '0; e_pop = '0; e_v = '0; n = 0; e_free = 0;
    for (int c = 0; c < NCLS; c++) begin
      e_cmp[c] = (c != 0) && mt[c] == 1;
      e_rel[c] = (c != 0) && (mrel[c] != 0 || (e_cmp[c] && mnp[c] != 0));
    end
    if (dr) begin
      for (int k = 0; k < NCLS; k++) begin
        best = -1;
        for (int c = 0; c < NCLS; c++)
          if (!seen[c] && mcnt[c] > 0 && (best < 0 || mseq[c][oldest(c)] < mseq[best][oldest(best)]))
            best = c;
        if (best < 0 || n == W) break;
        seen[best] = 1'b1; h = oldest(best);
        if (msq[best][h] != 0) e_pop[best] = 1'b1;
        else if (best == 0 || (fav[best] && !(mnp[best] != 0 && mt[best] != 0))) begin
          e_pop[best] = 1'b1; e_go[best] = 1'b1; e_v[n] = 1'b1;
          es[n] = mseq[best][h]; et[n] = mtid[best][h]; ec[n] = best; em[n] = mmem[best][h];
          if (mmem[best][h] == 0) e_free++;
          n++;
        end else e_busy[best] = 1'b1;
      end
    end
    chk(tag, "R2 slot valid", 32'(iss_valid), 32'(e_v));
    for (int i = 0; i < W; i++) if (e_v[i]) begin
      chk(tag, "R2 slot seq", 32'(iss_seq[i]), 32'(es[i]));
      chk(tag, "R2 slot tid", 32'(iss_tid[i]), 32'(et[i]));
      chk(tag, "R2 slot class", 32'(iss_cls[i]), 32'(ec[i]));
      chk(tag, "R11 slot mem", 32'(iss_mem[i]), 32'(em[i]));
    end
    chk(tag, "R6 busy skip", 32'(busy_skip), 32'(e_busy));
    chk(tag, "R11 entries freed", 32'(entry_free), 32'(e_free));
    chk(tag, "R8 unit release", 32'(fu_release), 32'(e_rel));
    chk(tag, "R9 completion", 32'(cmp_valid), 32'(e_cmp));
    for (int c = 1; c < NCLS; c++) if (e_cmp[c]) begin
      chk(tag, "R9 completion seq", 32'(cmp_seq[c]), 32'(mps[c]));
      chk(tag, "R9 completion tid", 32'(cmp_tid[c]), 32'(mpt[c]));
    end
    // advance the reference state to the next cycle
    full_pre = mcnt[p_c] >= DEPTH;
    for (int c = 1; c < NCLS; c++) begin
      nt = (mt[c] != 0) ? mt[c] - 1 : 0;
      mrel[c] = 0;
      if (e_go[c]) begin
        h = oldest(c);
        if (opl[c] > 1) begin
          nt = delay_of(isl[c]); mnp[c] = (isl[c] > 1); mrel[c] = !mnp[c];
          mps[c] = mseq[c][h]; mpt[c] = mtid[c][h];
        end else mrel[c] = 1;
      end
      mt[c] = nt;
    end
    for (int c = 0; c < NCLS; c++) if (e_pop[c]) begin
      h = oldest(c); nt = mcnt[c] - 1;
      mseq[c][h] = mseq[c][nt]; mtid[c][h] = mtid[c][nt];
      msq[c][h] = msq[c][nt]; mmem[c][h] = mmem[c][nt]; mcnt[c] = nt;
    end
    if (p_v && !full_pre) begin
      nt = mcnt[p_c];
      mseq[p_c][nt] = p_s; mtid[p_c][nt] = p_t; msq[p_c][nt] = p_q; mmem[p_c][nt] = p_m;
      mcnt[p_c] = nt + 1;
    end
    p_v = 0; p_q = 0; p_m = 0;
  endtask

  task automatic put(string tag, int c, int s, int t = 0, logic q = 0, logic m = 0);
    p_v = 1; p_c = c; p_s = s; p_t = t; p_q = q; p_m = m;
    step(tag);
  endtask

  task automatic drain(string tag, int k);
    dr = 1; fav = '1;
    repeat (k) step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seq_ctr, dummy;
    dummy = $urandom(24680);
    for (int c = 0; c < NCLS; c++) begin
      mcnt[c] = 0; mt[c] = 0; mnp[c] = 0; mrel[c] = 0; mps[c] = 0; mpt[c] = 0;
      opl[c] = 1; isl[c] = 1;
    end
    push_valid = 0; push_cls = 0; push_seq = 0; push_tid = 0; push_sq = 0; push_mem = 0;
    dn_ready = 0; fu_avail = '1; op_lat = '{default: 4'd1}; iss_lat = '{default: 4'd1};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: empty after reset, outputs quiet even with downstream open
    dr = 1; step("R1"); step("R1");
    // R4 while loading, then R2 age order across classes
    dr = 0;
    put("R4", 1, 30); put("R4", 2, 10, 1); put("R4", 3, 20, 2); step("R4");
    dr = 1; step("R2"); step("R2"); drain("R2", 3);
    // R3: older push overtakes an existing head
    dr = 0; put("R3", 1, 50); put("R3", 1, 5, 3); put("R3", 2, 40);
    dr = 1; step("R3"); step("R3"); drain("R3", 3);
    // R5: squashed head dropped without a slot
    dr = 0; put("R5", 1, 1, 0, 1); put("R5", 1, 60); put("R5", 2, 70); put("R5", 3, 80);
    dr = 1; step("R5"); step("R5"); drain("R5", 3);
    // R6: unavailable unit skips its class only
    dr = 0; put("R6", 1, 90); put("R6", 2, 95);
    dr = 1; fav = 4'b1101; step("R6"); step("R6"); drain("R6", 3);
    // R7: no-unit class ignores availability
    dr = 0; put("R7", 0, 7); put("R7", 0, 8);
    dr = 1; fav = '0; step("R7"); step("R7"); step("R7"); drain("R7", 3);
    // R9: pipelined multi-cycle unit
    opl[2] = 3; isl[2] = 1;
    dr = 0; put("R9", 2, 110, 1); put("R9", 2, 111, 2);
    dr = 1; repeat (4) step("R9"); drain("R9", 3);
    // R10: non-pipelined unit holds its class until completion
    opl[3] = 4; isl[3] = 3;
    dr = 0; put("R10", 3, 100, 1); put("R10", 3, 101, 2); put("R10", 1, 102);
    dr = 1; repeat (7) step("R10"); drain("R10", 3);
    // R11: memory instructions keep their entry
    dr = 0; put("R11", 1, 120, 0, 0, 1); put("R11", 2, 121);
    dr = 1; step("R11"); step("R11"); drain("R11", 3);
    // R12: push into a full queue is ignored
    opl[2] = 1;
    dr = 0;
    for (int i = 0; i < DEPTH; i++) put("R12", 2, 200 + i);
    put("R12", 2, 150);
    drain("R12", DEPTH + 3);
    // constrained random mix
    opl[1] = 1; isl[1] = 1; opl[2] = 3; isl[2] = 1; opl[3] = 4; isl[3] = 4;
    seq_ctr = 0;
    for (int k = 0; k < 400; k++) begin
      p_v = ($urandom % 10) < 6;
      p_c = $urandom % NCLS; p_t = $urandom % 4;
      p_s = {($urandom % 128), 9'(seq_ctr)};
      p_q = ($urandom % 8) == 0; p_m = ($urandom % 4) == 0;
      if (p_v) seq_ctr++;
      dr = ($urandom % 5) != 0; fav = 4'($urandom);
      step("R2");
    end
    drain("R2", 40);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule